// File: doc/BRIEF.md
# Unpack Element Write-Mask Unit

This block sits between an unpack engine and vector memory. Each cycle the unpack engine presents a vector of four 32-bit lanes. The vector carries the current write-cycle index, the unpack command and the contents that memory already holds at the target address. For each lane the unit decides whether to write the unpacked value, a per-lane row constant, a per-cycle column constant, or nothing at all. It returns the final vector together with one write enable per lane, one clock later.

A 32-bit mask configuration word holds sixteen 2-bit lane codes, four for each of four write cycles. The cycle index picks which group of four codes applies. Any index above 3 uses the last group. A single enable bit in the unpack command turns masking on. With it clear, every lane is written with the unpacked data.

Top module: `elem_wmask`

## Requirements
- R1: Lane code for cycle c and lane k is taken from mask_cfg bits [2i+1:2i] with i = 4c + k. Each lane uses its own code within the same vector.
- R2: Code 0 makes the lane output equal the data_vec lane (lane k at bits 32k+31:32k), with its write enable set.
- R3: Code 1 makes the lane output equal row_vec entry k (bits 32k+31:32k) for lane k, with its write enable set.
- R4: Code 2 makes the lane output equal col_vec entry c (bits 32c+31:32c) for the selected cycle c, with its write enable set.
- R5: Code 3 protects the lane. Its write enable is clear and its output equals the mem_vec lane, so memory keeps its contents.
- R6: A cyc_idx value of 3 or more selects cycle 3, both for the code group and for the column entry.
- R7: When cmd bit 4 is clear, every lane outputs data_vec with its write enable set, whatever mask_cfg holds.
- R8: Outputs are registered with one cycle of latency. out_valid follows in_valid by one cycle. out_we is all zero whenever out_valid is low.
- R9: While rst_n is low, out_valid, out_we and out_vec are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input vector is present this cycle |
| cmd | input | 8 | Unpack command; bit 4 enables masking |
| mask_cfg | input | 32 | Sixteen 2-bit lane codes |
| cyc_idx | input | 8 | Current write-cycle index |
| row_vec | input | 128 | Four row constants, one per lane |
| col_vec | input | 128 | Four column constants, one per cycle |
| data_vec | input | 128 | Unpacked vector |
| mem_vec | input | 128 | Current memory contents at the target |
| out_valid | output | 1 | Output vector is valid |
| out_vec | output | 128 | Final vector |
| out_we | output | 4 | Per-lane write enables |

## Verification
Write protection and constant substitution can land in the same cycle, in different lanes of one vector. Cycle saturation can also coincide with column selection. The bench provokes the first with mixed code bytes such as 0xE4, which put pass, row, column and protect side by side. It provokes the second with out-of-range cycle indices against masks that select columns. Each result is judged lane by lane: out_vec is compared with a model built from the requirements, and out_we with a tabulated expected enable pattern.

// File: rtl/elem_wmask_pkg.sv
package elem_wmask_pkg;
   typedef enum logic [1:0] {
      WM_PASS = 2'd0,
      WM_ROW  = 2'd1,
      WM_COL  = 2'd2,
      WM_KEEP = 2'd3
   } wm_code_e;
endpackage

// File: rtl/elem_wmask_cycsel.sv
module elem_wmask_cycsel #(
   parameter int LANES  = 4,
   parameter int CYCLES = 4,
   parameter int CYC_W  = 8,
   localparam int SEL_W  = (CYCLES > 1) ? $clog2(CYCLES) : 1,
   localparam int MASK_W = 2 * LANES * CYCLES
) (
   input  logic [CYC_W-1:0]   cyc_idx,
   input  logic [MASK_W-1:0]  mask_cfg,
   output logic [SEL_W-1:0]   sel,
   output logic [2*LANES-1:0] codes
);
   localparam logic [CYC_W-1:0] LAST = CYC_W'(CYCLES - 1);

   always_comb begin
      if (cyc_idx >= LAST) sel = SEL_W'(CYCLES - 1);
      else                 sel = cyc_idx[SEL_W-1:0];
      codes = mask_cfg[sel*2*LANES +: 2*LANES];
   end
endmodule

// File: rtl/elem_wmask_lane.sv
module elem_wmask_lane
   import elem_wmask_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          en,
   input  logic [1:0]    code,
   input  logic [DW-1:0] data,
   input  logic [DW-1:0] row,
   input  logic [DW-1:0] col,
   input  logic [DW-1:0] mem,
   output logic [DW-1:0] val,
   output logic          we
);
   wm_code_e eff;

   always_comb begin
      eff = en ? wm_code_e'(code) : WM_PASS;
      we  = 1'b1;
      unique case (eff)
         WM_PASS: val = data;
         WM_ROW:  val = row;
         WM_COL:  val = col;
         WM_KEEP: begin
            val = mem;
            we  = 1'b0;
         end
         default: val = data;
      endcase
   end
endmodule

// File: rtl/elem_wmask.sv
module elem_wmask
   import elem_wmask_pkg::*;
#(
   parameter int DW          = 32,
   parameter int LANES       = 4,
   parameter int CYCLES      = 4,
   parameter int CYC_W       = 8,
   parameter int CMD_W       = 8,
   parameter int MASK_EN_BIT = 4,
   localparam int SEL_W  = (CYCLES > 1) ? $clog2(CYCLES) : 1,
   localparam int MASK_W = 2 * LANES * CYCLES,
   localparam int VW     = DW * LANES,
   localparam int CW     = DW * CYCLES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CMD_W-1:0]  cmd,
   input  logic [MASK_W-1:0] mask_cfg,
   input  logic [CYC_W-1:0]  cyc_idx,
   input  logic [VW-1:0]     row_vec,
   input  logic [CW-1:0]     col_vec,
   input  logic [VW-1:0]     data_vec,
   input  logic [VW-1:0]     mem_vec,
   output logic              out_valid,
   output logic [VW-1:0]     out_vec,
   output logic [LANES-1:0]  out_we
);
   generate
      if (MASK_EN_BIT >= CMD_W) begin : g_bad_bit
         $error("MASK_EN_BIT outside cmd");
      end
      if ((1 << CYC_W) < CYCLES) begin : g_bad_cyc
         $error("CYC_W too narrow for CYCLES");
      end
   endgenerate

   logic [SEL_W-1:0]   sel;
   logic [2*LANES-1:0] codes;
   logic [DW-1:0]      col_sel;
   logic [VW-1:0]      nxt_vec;
   logic [LANES-1:0]   nxt_we;
   logic               mask_en;

   assign mask_en = cmd[MASK_EN_BIT];

   elem_wmask_cycsel #(.LANES(LANES), .CYCLES(CYCLES), .CYC_W(CYC_W)) u_cycsel (
      .cyc_idx (cyc_idx),
      .mask_cfg(mask_cfg),
      .sel     (sel),
      .codes   (codes)
   );

   assign col_sel = col_vec[sel*DW +: DW];

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         elem_wmask_lane #(.DW(DW)) u_lane (
            .en  (mask_en),
            .code(codes[2*k +: 2]),
            .data(data_vec[k*DW +: DW]),
            .row (row_vec[k*DW +: DW]),
            .col (col_sel),
            .mem (mem_vec[k*DW +: DW]),
            .val (nxt_vec[k*DW +: DW]),
            .we  (nxt_we[k])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_we    <= '0;
         out_vec   <= '0;
      end else begin
         out_valid <= in_valid;
         out_we    <= in_valid ? nxt_we : '0;
         if (in_valid) out_vec <= nxt_vec;
      end
   end

   // R8: output follows input valid by exactly one cycle
   assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   // R8: no write enable without a valid output
   assert_we_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> out_we == '0);

   // R7: masking disabled passes every lane
   assert_nomask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !$past(cmd[MASK_EN_BIT]) |->
         (out_we == '1) && (out_vec == $past(data_vec)));

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_chk
         // R5: a disabled lane carries the memory contents it saw
         assert_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid && !out_we[k] |->
               out_vec[k*DW +: DW] == $past(mem_vec[k*DW +: DW]));
      end
   endgenerate
endmodule

// File: tb/tb_elem_wmask.sv
module tb_elem_wmask;
   localparam int NT = 12;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [7:0]   cmd = '0;
   logic [31:0]  mask_cfg = '0;
   logic [7:0]   cyc_idx = '0;
   logic [127:0] row_vec, col_vec, data_vec, mem_vec;
   logic         out_valid;
   logic [127:0] out_vec;
   logic [3:0]   out_we;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   elem_wmask dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cmd(cmd),
      .mask_cfg(mask_cfg), .cyc_idx(cyc_idx), .row_vec(row_vec),
      .col_vec(col_vec), .data_vec(data_vec), .mem_vec(mem_vec),
      .out_valid(out_valid), .out_vec(out_vec), .out_we(out_we)
   );

   localparam logic [31:0] T_MASK [NT] = '{
      32'h0000_0000, 32'h5555_5555, 32'hAAAA_AAAA, 32'hFFFF_FFFF,
      32'h0000_00E4, 32'h0000_00E4, 32'hE400_0000, 32'hE400_0000,
      32'hAA00_0000, 32'hFFFF_FFFF, 32'h5555_5555, 32'h1B00_0000};
   localparam logic [7:0] T_CYC [NT] = '{
      8'd0, 8'd0, 8'd1, 8'd2, 8'd0, 8'd1, 8'd3, 8'd9, 8'd255, 8'd2, 8'd0, 8'd4};
   localparam logic [7:0] T_CMD [NT] = '{
      8'h10, 8'h10, 8'h10, 8'h10, 8'h10, 8'h10, 8'h10, 8'h10, 8'h10,
      8'h0F, 8'hEF, 8'h10};
   localparam logic [3:0] T_WE [NT] = '{
      4'hF, 4'hF, 4'hF, 4'h0, 4'h7, 4'hF, 4'h7, 4'h7, 4'hF, 4'hF, 4'hF, 4'hE};
   string tags [NT];

   function automatic logic [31:0] exp_lane(logic [31:0] m, logic [7:0] c,
                                            logic [7:0] cm, int k);
      int sat = (c > 3) ? 3 : int'(c);
      logic [1:0] code = m[2*(sat*4+k) +: 2];
      if (!cm[4]) code = 2'd0;
      case (code)
         2'd0:    return 32'hD000_0000 | 32'(k);
         2'd1:    return 32'hA000_0000 | 32'(k);
         2'd2:    return 32'hC000_0000 | 32'(sat);
         default: return 32'hE000_0000 | 32'(k);
      endcase
   endfunction

   task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic apply(logic [31:0] m, logic [7:0] c, logic [7:0] cm);
      @(negedge clk);
      in_valid = 1'b1; mask_cfg = m; cyc_idx = c; cmd = cm;
      @(posedge clk);
      #1;
   endtask

   initial begin
      for (int k = 0; k < 4; k++) begin
         row_vec[32*k +: 32]  = 32'hA000_0000 | 32'(k);
         col_vec[32*k +: 32]  = 32'hC000_0000 | 32'(k);
         data_vec[32*k +: 32] = 32'hD000_0000 | 32'(k);
         mem_vec[32*k +: 32]  = 32'hE000_0000 | 32'(k);
      end
      tags = '{"R2", "R3", "R4", "R5", "R1", "R1", "R1", "R6", "R6", "R7", "R7", "R6"};
      #12;
      // R9: reset state
      check("R9 reset valid", 128'(out_valid), 128'd0);
      check("R9 reset we", 128'(out_we), 128'd0);
      check("R9 reset vec", out_vec, 128'd0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check("R8 idle valid", 128'(out_valid), 128'd0);

      for (int t = 0; t < NT; t++) begin
         logic [127:0] ev;
         apply(T_MASK[t], T_CYC[t], T_CMD[t]);
         for (int k = 0; k < 4; k++)
            ev[32*k +: 32] = exp_lane(T_MASK[t], T_CYC[t], T_CMD[t], k);
         check({tags[t], " vec"}, out_vec, ev);
         check({tags[t], " we"}, 128'(out_we), 128'(T_WE[t]));
         check("R8 valid", 128'(out_valid), 128'd1);
      end

      // R8: changing inputs after the edge do not reach the outputs
      @(negedge clk);
      in_valid = 1'b0; mask_cfg = 32'hFFFF_FFFF; cmd = 8'h10;
      #1;
      check("R8 hold we", 128'(out_we), 128'hE);
      @(posedge clk); #1;
      check("R8 drop valid", 128'(out_valid), 128'd0);
      check("R8 drop we", 128'(out_we), 128'd0);

      // R5 with R4 mixed lanes at saturated cycle: codes 2,3,2,3
      apply(32'hEE00_0000, 8'd200, 8'h10);
      check("R5 mixed we", 128'(out_we), 128'h5);
      check("R4 mixed vec", out_vec,
            {32'hE000_0003, 32'hC000_0003, 32'hE000_0001, 32'hC000_0003});

      // R9: reset mid-stream
      @(negedge clk); rst_n = 1'b0; #1;
      check("R9 async valid", 128'(out_valid), 128'd0);
      check("R9 async vec", out_vec, 128'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule